// File: doc/BRIEF.md
# Three-Wire Sampling ADC Readout Controller

This block sits on the host side of a three-wire link to a micropower sampling analog-to-digital converter. The link has an active-low chip select, a serial clock and a serial data return. When it receives a start request, the controller drives chip select low. It then generates the serial clock from the system clock with a fixed divide ratio and samples the data line on every rising serial-clock edge. The converter updates the line on falling edges.

Each frame opens with a fixed preamble of three rising edges: two for the input sampling window and one for the null bit. The controller discards these. The next twelve rising edges carry the conversion result, most significant bit first, as straight binary from 0 to 4095. On the falling edge that follows the last useful bit, the controller returns chip select high so the converter powers down. In the same cycle it presents the word with a one-cycle valid strobe.

An optional echo mode keeps the clock running for eleven more edges. These capture the least-significant-first repeat of bits 1 through 11, which is compared with the main word and flagged on disagreement. Chip select then stays high for a programmable number of system clocks before the next frame may begin.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy, valid and mismatch are all low.
- R2: While chip select is low, every serial-clock level lasts exactly HALF_DIV system clocks, the first rising edge coming HALF_DIV clocks after chip select falls. While chip select is high, the serial clock is low.
- R3: The first three rising edges of a frame (two sampling edges and the null bit) do not affect the result, whatever level the data line holds during them.
- R4: Rising edges 4 to 15 capture result bits 11 down to 0 in that order, so the result equals the twelve sampled bits read as a straight binary number.
- R5: With echo mode off, a frame has exactly 15 rising edges. Chip select rises together with the falling edge after the 15th, and valid is high for exactly that one cycle with the result.
- R6: With echo mode on (echo_en sampled at the accepted start), a frame has exactly 26 rising edges. Edges 16 to 26 carry bits 1 to 11 in ascending order. Mismatch, valid with the result, is high exactly when any of them differs from the same bit of the result.
- R7: With echo mode off, mismatch is low whenever valid is high.
- R8: After chip select rises, it stays high for at least GAP+1 system clocks, and exactly GAP+1 when a start request is held waiting. A start request that is dropped before the gap ends starts no frame.
- R9: A start request while busy is ignored and produces no extra frame or valid pulse.
- R10: Busy is high from the cycle after a start is accepted until the end of the gap that follows the frame, and it is high whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion frame |
| echo_en | input | 1 | Capture and check the least-significant-first repeat in this frame |
| sdi | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame in progress or inter-frame gap running |
| valid | output | 1 | One-cycle strobe marking a new result |
| result | output | DATA_W | Conversion result, straight binary |
| mismatch | output | 1 | Echo disagreed with the result (valid with `valid`) |

## Verification
Two functions can fall in one cycle: the end of the inter-frame gap, and the acceptance of a start request. The valid strobe of one frame can also coincide with a new start request. The bench provokes both by holding start high from the moment each frame ends, so the request is pending at the exact cycle the gap expires. It judges the outcome from the measured chip-select high time, which must equal GAP+1 clocks, and from a valid count that must match the scoreboard. Separately, start pulses placed mid-frame and mid-gap must leave the chip-select and valid activity unchanged.

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int DATA_W   = 12,
  parameter int SKIP     = 3,
  parameter int HALF_DIV = 500,
  parameter int GAP      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              echo_en,
  input  logic              sdi,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] result,
  output logic              mismatch
);
  localparam int NB  = SKIP + DATA_W;
  localparam int NE  = NB + DATA_W - 1;
  localparam int RCW = $clog2(NE + 1);
  localparam int DVW = $clog2(HALF_DIV + 1);
  localparam int GW  = $clog2(GAP + 1);
  localparam logic [RCW-1:0] SKIP_C = RCW'(SKIP);
  localparam logic [RCW-1:0] NB_C   = RCW'(NB);
  localparam logic [RCW-1:0] NE_C   = RCW'(NE);
  localparam logic [DVW-1:0] DIV_M1 = DVW'(HALF_DIV - 1);

  logic              run, echo_q;
  logic [DVW-1:0]    div_cnt;
  logic [RCW-1:0]    rcnt;
  logic [GW-1:0]     gap_cnt;
  logic [DATA_W-1:0] word;
  logic [DATA_W-2:0] echo;

  wire [RCW-1:0] r_next = rcnt + 1'b1;
  wire [RCW-1:0] last   = echo_q ? NE_C : NB_C;
  wire           tick   = div_cnt == DIV_M1;

  assign busy = run || (gap_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      echo_q   <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      div_cnt  <= '0;
      rcnt     <= '0;
      gap_cnt  <= '0;
      word     <= '0;
      echo     <= '0;
      valid    <= 1'b0;
      result   <= '0;
      mismatch <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!run) begin
        if (gap_cnt != '0) begin
          gap_cnt <= gap_cnt - 1'b1;
        end else if (start) begin
          run     <= 1'b1;
          cs_n    <= 1'b0;
          echo_q  <= echo_en;
          div_cnt <= '0;
          rcnt    <= '0;
        end
      end else if (!tick) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rcnt <= r_next;
          if (r_next > SKIP_C && r_next <= NB_C)
            word <= {word[DATA_W-2:0], sdi};
          else if (r_next > NB_C)
            echo <= {sdi, echo[DATA_W-2:1]};
        end else begin
          sclk <= 1'b0;
          if (rcnt == last) begin
            run      <= 1'b0;
            cs_n     <= 1'b1;
            valid    <= 1'b1;
            result   <= word;
            mismatch <= echo_q && (echo != word[DATA_W-1:1]);
            gap_cnt  <= GW'(GAP);
          end
        end
      end
    end
  end

  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_valid_at_cs_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));
  assert_no_echo_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !echo_q) |-> !mismatch);
  assert_gap_before_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));
  assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  assert_gap_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);
endmodule

// File: tb/serial_adc_reader_tb.sv
module serial_adc_reader_tb;
  localparam int W = 12;
  localparam int HD = 3;
  localparam int GP = 5;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic echo_en = 1'b0;
  logic sdi;
  logic cs_n, sclk, busy, valid, mismatch;
  logic [W-1:0] result;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_adc_reader #(.DATA_W(W), .SKIP(3), .HALF_DIV(HD), .GAP(GP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .echo_en(echo_en), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .valid(valid), .result(result),
    .mismatch(mismatch));

  // converter model
  logic [W-1:0] m_word = '0;
  int m_bad = 0;
  logic m_pre = 1'b1;
  int fcnt = 0;
  always @(negedge cs_n) fcnt = 0;
  always @(negedge sclk) if (!cs_n) fcnt = fcnt + 1;
  always_comb begin
    if (cs_n) sdi = 1'b1;
    else if (fcnt < 2) sdi = m_pre;
    else if (fcnt == 2) sdi = 1'b0;
    else if (fcnt <= 14) sdi = m_word[14 - fcnt];
    else if (fcnt <= 25) sdi = m_word[fcnt - 14] ^ (m_bad == fcnt - 14);
    else sdi = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed { logic [W-1:0] d; logic mm; logic [5:0] edges; } exp_t;
  exp_t q[$];
  int nvalid = 0;

  task automatic frame(input logic [W-1:0] d, input bit echo, input int bad, input bit pre);
    exp_t e;
    @(negedge clk);
    while (!cs_n) @(negedge clk);
    m_word = d; m_bad = bad; m_pre = pre;
    echo_en = echo;
    start = 1'b1;
    e.d = d; e.mm = echo && (bad != 0); e.edges = echo ? 6'd26 : 6'd15;
    q.push_back(e);
    @(negedge clk);
    while (cs_n) @(negedge clk);
    start = 1'b0;
    while (!valid) @(negedge clk);
  endtask

  // monitor
  logic p_cs = 1'b1, p_sclk = 1'b0;
  int hp = 0, rises = 0, hi_len = 0;
  bit seen_frame = 0, held = 0, hp_ok = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        hp = 0; rises = 0; hp_ok = 1;
        if (seen_frame) begin
          chk(hi_len >= GP + 1, "R8 cs high min", hi_len, GP + 1);
          if (held) chk(hi_len == GP + 1, "R8 cs high exact", hi_len, GP + 1);
        end
        seen_frame = 1;
      end else if (!p_cs || !cs_n) begin
        if (sclk != p_sclk) begin
          if (hp != HD - 1) hp_ok = 0;
          if (sclk) rises++;
          hp = 0;
        end else hp++;
      end
      if (cs_n) begin
        if (!p_cs) hi_len = 1; else hi_len++;
        chk(!sclk, "R2 sclk low while idle", sclk, 0);
      end
      if (!cs_n) chk(busy, "R10 busy while cs low", busy, 1);
      if (valid) begin
        exp_t e;
        nvalid++;
        chk(!p_cs && cs_n, "R5 valid with cs rise", cs_n, 1);
        chk(hp_ok, "R2 half period", hp, HD - 1);
        if (q.size() == 0) chk(0, "R9 unexpected frame", nvalid, nvalid - 1);
        else begin
          e = q.pop_front();
          chk(result == e.d, "R4 result", result, e.d);
          chk(mismatch == e.mm, e.edges == 26 ? "R6 mismatch" : "R7 mismatch", mismatch, e.mm);
          chk(rises == e.edges, e.edges == 26 ? "R6 edge count" : "R5 edge count", rises, e.edges);
        end
      end
      p_cs = cs_n; p_sclk = sclk;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(valid == 1'b0 && mismatch == 1'b0, "R1 valid/mismatch", valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4: patterns with both preamble levels
    frame(12'hA5A, 0, 0, 1);
    frame(12'h000, 0, 0, 1);
    frame(12'hFFF, 0, 0, 0);
    frame(12'h800, 0, 0, 1);
    frame(12'h001, 0, 0, 0);
    // R6 echo mode
    frame(12'h5A5, 1, 0, 1);
    frame(12'h3C7, 1, 4, 0);
    frame(12'hFFF, 1, 11, 1);
    frame(12'h001, 1, 1, 0);
    // R8 back-to-back: start held through the gap
    held = 1;
    frame(12'h123, 0, 0, 1);
    frame(12'hABC, 1, 0, 0);
    frame(12'h7FF, 0, 0, 1);
    held = 0;

    // R9: start pulses mid-frame are ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    m_word = 12'h456; m_bad = 0; echo_en = 0;
    start = 1'b1; q.push_back('{d: 12'h456, mm: 1'b0, edges: 6'd15});
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!valid) @(negedge clk);
    // R8: pulse during gap is dropped
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4 * GP) @(negedge clk);
    chk(cs_n == 1'b1, "R8 start in gap ignored", cs_n, 1);
    chk(nvalid == 13, "R9 valid count", nvalid, 13);
    chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    chk(busy == 1'b0, "R10 idle after gap", busy, 0);
    finish_run();
  end
endmodule